// File: doc/BRIEF.md
# Radio-State GPIO Pin Controller

This block drives two banks of general-purpose pins for a radio front end. One bank belongs to the receive side and one to the transmit side. Each pin can be an output or an input. When it is an output, its level comes from one of three sources: a value that software writes, a value looked up from the current radio state, or one of two internal debug buses. The radio state comes from two status inputs that say whether the transmitter and the receiver are running.

Software reaches the block through a single-cycle word write port. A combinational read port returns the stored settings and the sampled levels of the pins. Every pin has its own direction, select and debug bits, so one bank can mix all three sources. A table holds one word per bank for each of the four radio states. The looked-up word is registered, so a state change reaches the pins one clock after the status inputs change.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: After reset every stored register reads 0, every output enable is 0 and every pin output is 0.
- R2: A pin's output enable equals its direction bit; a pin whose direction bit is 0 drives 0 on its output.
- R3: With debug bit 0 and select bit 0, an output pin drives its bank's software value bit (word 0 receive, word 1 transmit).
- R4: With debug bit 0 and select bit 1, an output pin drives the matching bit of its bank's table word for the current radio state.
- R5: The table sits at words 8 to 15, ordered idle, transmit-only, receive-only, full duplex, with the receive-side word first in each pair. The state is taken from tx_active and rx_active: both 0 is idle, only tx_active is transmit-only, only rx_active is receive-only, both 1 is full duplex.
- R6: A change of tx_active/rx_active, or a write to a table word, reaches the pins exactly one clock later; until then the pins keep the previous table value.
- R7: With debug bit 1, an output pin drives debug bus 0 when its select bit is 0 and debug bus 1 when its select bit is 1.
- R8: Reading word 0 or word 1 returns the receive or transmit pin levels sampled on the previous clock. Reading words 2 to 15 returns the stored value (direction 2/3, select 4/5, debug 6/7 for receive/transmit). Reading any address at 16 or above returns 0.
- R9: A write to an address at 16 or above changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_addr |
| tx_active | input | 1 | Transmitter running |
| rx_active | input | 1 | Receiver running |
| rx_pin_in | input | W | Receive bank pin levels |
| tx_pin_in | input | W | Transmit bank pin levels |
| rx_dbg0 | input | W | Receive bank debug bus 0 |
| rx_dbg1 | input | W | Receive bank debug bus 1 |
| tx_dbg0 | input | W | Transmit bank debug bus 0 |
| tx_dbg1 | input | W | Transmit bank debug bus 1 |
| rx_pin_out | output | W | Receive bank output levels |
| rx_pin_oe | output | W | Receive bank output enables |
| tx_pin_out | output | W | Transmit bank output levels |
| tx_pin_oe | output | W | Transmit bank output enables |

## Verification
The bench builds the block with W=4 and AW=5. With that width every direction, select and debug pattern of a bank, 4096 in all, can be swept under all four radio states. Each pin then meets every source choice next to neighbours that use other sources. AW=5 leaves sixteen unmapped addresses, so the bench can check that reads and writes there do nothing.

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          tx_active,
  input  logic          rx_active,
  input  logic [W-1:0]  rx_pin_in,
  input  logic [W-1:0]  tx_pin_in,
  input  logic [W-1:0]  rx_dbg0,
  input  logic [W-1:0]  rx_dbg1,
  input  logic [W-1:0]  tx_dbg0,
  input  logic [W-1:0]  tx_dbg1,
  output logic [W-1:0]  rx_pin_out,
  output logic [W-1:0]  rx_pin_oe,
  output logic [W-1:0]  tx_pin_out,
  output logic [W-1:0]  tx_pin_oe
);
  localparam int IW    = 4;
  localparam int NREG  = 1 << IW;
  localparam int DIR_W = 2;
  localparam int SEL_W = 4;
  localparam int DBG_W = 6;

  logic [W-1:0]  regs [NREG];
  logic [W-1:0]  pin_q [2];
  logic [W-1:0]  atr_q [2];
  logic [W-1:0]  pin_in [2];
  logic [W-1:0]  dbg0 [2];
  logic [W-1:0]  dbg1 [2];
  logic [W-1:0]  pout [2];
  logic [W-1:0]  poe [2];
  logic [1:0]    st;
  logic          in_map;
  logic [IW-1:0] idx;

  assign in_map = (reg_addr < AW'(NREG));
  assign idx    = reg_addr[IW-1:0];
  assign st     = {rx_active, tx_active};

  assign pin_in[0] = rx_pin_in;
  assign pin_in[1] = tx_pin_in;
  assign dbg0[0]   = rx_dbg0;
  assign dbg0[1]   = tx_dbg0;
  assign dbg1[0]   = rx_dbg1;
  assign dbg1[1]   = tx_dbg1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (reg_we && in_map) begin
      regs[idx] <= reg_wdata;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [W-1:0] dir, sel, dbg, swv, norm, alt;

    assign dir = regs[DIR_W + b];
    assign sel = regs[SEL_W + b];
    assign dbg = regs[DBG_W + b];
    assign swv = regs[b];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        atr_q[b] <= '0;
        pin_q[b] <= '0;
      end else begin
        atr_q[b] <= regs[{1'b1, st, 1'(b)}];
        pin_q[b] <= pin_in[b];
      end
    end

    assign norm    = (sel & atr_q[b]) | (~sel & swv);
    assign alt     = (sel & dbg1[b])  | (~sel & dbg0[b]);
    assign pout[b] = dir & ((dbg & alt) | (~dbg & norm));
    assign poe[b]  = dir;
  end

  assign rx_pin_out = pout[0];
  assign rx_pin_oe  = poe[0];
  assign tx_pin_out = pout[1];
  assign tx_pin_oe  = poe[1];

  always_comb begin
    if (!in_map)       reg_rdata = '0;
    else if (idx < 2)  reg_rdata = pin_q[idx[0]];
    else               reg_rdata = regs[idx];
  end
endmodule

// File: rtl/atr_gpio_ctrl_chk.sv
module atr_gpio_ctrl_chk #(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  reg_rdata,
  input logic          tx_active,
  input logic          rx_active,
  input logic [W-1:0]  rx_dbg0,
  input logic [W-1:0]  rx_dbg1,
  input logic [W-1:0]  tx_dbg0,
  input logic [W-1:0]  tx_dbg1,
  input logic [W-1:0]  rx_pin_out,
  input logic [W-1:0]  rx_pin_oe,
  input logic [W-1:0]  tx_pin_out,
  input logic [W-1:0]  tx_pin_oe
);
  localparam int NREG = 16;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rx_pin_oe == '0 && tx_pin_oe == '0 && rx_pin_out == '0 && tx_pin_out == '0)); // R1

  AST_INPUT_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_pin_out & ~rx_pin_oe) == '0) && ((tx_pin_out & ~tx_pin_oe) == '0)); // R2

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && reg_we && reg_addr == AW'(2)) |=> (rx_pin_oe == $past(reg_wdata))); // R2

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !$past(reg_we) && $stable({tx_active, rx_active}))
    |=> (!$stable({rx_dbg0, rx_dbg1, tx_dbg0, tx_dbg1}) || $stable({rx_pin_out, tx_pin_out}))); // R6

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= AW'(NREG)) |-> (reg_rdata == '0)); // R8

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && reg_we && reg_addr >= AW'(NREG)) |=> $stable({rx_pin_oe, tx_pin_oe})); // R9
endmodule

bind atr_gpio_ctrl atr_gpio_ctrl_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .tx_active(tx_active), .rx_active(rx_active),
  .rx_dbg0(rx_dbg0), .rx_dbg1(rx_dbg1), .tx_dbg0(tx_dbg0), .tx_dbg1(tx_dbg1),
  .rx_pin_out(rx_pin_out), .rx_pin_oe(rx_pin_oe),
  .tx_pin_out(tx_pin_out), .tx_pin_oe(tx_pin_oe)
);

// File: tb/atr_gpio_ctrl_bench.sv
module atr_gpio_ctrl_bench;
  localparam int W  = 4;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          tx_active = 1'b0, rx_active = 1'b0;
  logic [W-1:0]  rx_pin_in = '0, tx_pin_in = '0;
  logic [W-1:0]  rx_dbg0 = 4'h3, rx_dbg1 = 4'hC, tx_dbg0 = 4'h6, tx_dbg1 = 4'h9;
  logic [W-1:0]  rx_pin_out, rx_pin_oe, tx_pin_out, tx_pin_oe;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  // table words per state index: 0 idle, 1 tx only, 2 rx only, 3 full
  logic [W-1:0] atr_rx [4] = '{4'h1, 4'h2, 4'h4, 4'h8};
  logic [W-1:0] atr_tx [4] = '{4'hE, 4'hD, 4'hB, 4'h7};
  localparam logic [W-1:0] IO_RX = 4'hA;
  localparam logic [W-1:0] IO_TX = 4'h5;

  always #4 clk = ~clk;

  atr_gpio_ctrl #(.W(W), .AW(AW)) u_atr_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_active(tx_active), .rx_active(rx_active),
    .rx_pin_in(rx_pin_in), .tx_pin_in(tx_pin_in),
    .rx_dbg0(rx_dbg0), .rx_dbg1(rx_dbg1), .tx_dbg0(tx_dbg0), .tx_dbg1(tx_dbg1),
    .rx_pin_out(rx_pin_out), .rx_pin_oe(rx_pin_oe),
    .tx_pin_out(tx_pin_out), .tx_pin_oe(tx_pin_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int sidx(input logic tx, input logic rx);
    return (tx && rx) ? 3 : tx ? 1 : rx ? 2 : 0;
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] dir, sel, dbg, io, atr, d0, d1);
    return dir & ((dbg & ((sel & d1) | (~sel & d0))) | (~dbg & ((sel & atr) | (~sel & io))));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      misses++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_oe", rx_pin_oe, '0);
    check("R1 tx_oe", tx_pin_oe, '0);
    check("R1 rx_out", rx_pin_out, '0);
    check("R1 tx_out", tx_pin_out, '0);
    for (int a = 2; a < 16; a++) begin
      reg_addr = AW'(a); #1;
      check("R1 reg clear", reg_rdata, '0);
    end

    // load software values and the table (R5 ordering)
    wr(0, IO_RX); wr(1, IO_TX);
    for (int s = 0; s < 4; s++) begin
      wr(8 + 2*s, atr_rx[s]);
      wr(9 + 2*s, atr_tx[s]);
    end

    // R8 readback of stored words and sampled pins
    for (int s = 0; s < 4; s++) begin
      reg_addr = AW'(8 + 2*s); #1; check("R8 rb rx table", reg_rdata, atr_rx[s]);
      reg_addr = AW'(9 + 2*s); #1; check("R8 rb tx table", reg_rdata, atr_tx[s]);
    end
    rx_pin_in = 4'h9; tx_pin_in = 4'h6;
    @(negedge clk);
    reg_addr = AW'(0); #1; check("R8 rx pins", reg_rdata, 4'h9);
    reg_addr = AW'(1); #1; check("R8 tx pins", reg_rdata, 4'h6);
    for (int a = 16; a < 32; a++) begin
      reg_addr = AW'(a); #1; check("R8 unmapped read", reg_rdata, '0);
    end

    // R9 unmapped write has no effect
    wr(2, 4'h5); wr(3, 4'hA);
    wr(18, 4'hF); wr(31, 4'hF);
    @(negedge clk);
    check("R9 rx_oe", rx_pin_oe, 4'h5);
    check("R9 tx_oe", tx_pin_oe, 4'hA);
    for (int a = 4; a < 8; a++) begin
      reg_addr = AW'(a); #1; check("R9 reg kept", reg_rdata, '0);
    end
    reg_addr = AW'(8); #1; check("R9 table kept", reg_rdata, atr_rx[0]);

    // R6 latency: table value follows the state one clock later
    wr(2, 4'hF); wr(4, 4'hF); wr(6, 4'h0);
    tx_active = 1'b0; rx_active = 1'b0;
    @(negedge clk);
    check("R6 idle settled", rx_pin_out, atr_rx[0]);
    tx_active = 1'b1; rx_active = 1'b1; #1;
    check("R6 before edge", rx_pin_out, atr_rx[0]);
    @(negedge clk);
    check("R6 after edge", rx_pin_out, atr_rx[3]);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(14); reg_wdata = 4'h6;
    @(negedge clk);
    reg_we = 1'b0;
    check("R6 table write lag", rx_pin_out, atr_rx[3]);
    @(negedge clk);
    check("R6 table write seen", rx_pin_out, 4'h6);
    wr(14, atr_rx[3]);

    // exhaustive sweep over direction, select and debug patterns
    // R2 R3 R4 R5 R7
    for (int dir = 0; dir < 16; dir++) begin
      for (int sel = 0; sel < 16; sel++) begin
        for (int dbg = 0; dbg < 16; dbg++) begin
          logic [W-1:0] d, s, g, ts, tg;
          d = W'(dir); s = W'(sel); g = W'(dbg);
          ts = ~s; tg = g ^ s;
          wr(2, d); wr(4, s); wr(6, g);
          wr(3, d); wr(5, ts); wr(7, tg);
          for (int st = 0; st < 4; st++) begin
            tx_active = st[1]; rx_active = st[0];
            @(negedge clk);
            check("R2 rx_oe", rx_pin_oe, d);
            check("R4 R5 R7 R3 rx_out", rx_pin_out,
                  model(d, s, g, IO_RX, atr_rx[sidx(st[1], st[0])], rx_dbg0, rx_dbg1));
            check("R4 R5 R7 R3 tx_out", tx_pin_out,
                  model(d, ts, tg, IO_TX, atr_tx[sidx(st[1], st[0])], tx_dbg0, tx_dbg1));
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule